// File: doc/BRIEF.md
# Mask-Compare Bus Address Decoder

This block sits between one CPU load/store port and a small set of target regions. Each physical access is first checked for natural alignment. An aligned access is then decoded against a parameterised table of regions. The block drives a one-hot target select and the offset of the address within the chosen region. It holds the completion back by that region's read or write wait-state count, then pulses ready with either an ok flag or a two-bit error code.

Each region has a base, a size, a signed read delay, a signed write delay and a valid bit, all written through a configuration port. The size is rounded up to a power of two. One region, chosen by parameter, acts as the memory-controller region. It is looked up before all others, wins on any overlap and has no valid gate. A last-hit register remembers the most recently matched region. Among overlapping ordinary regions it is preferred over the plain lowest-index scan.

Top module: `region_decoder`

## Requirements
- R1: A region matches when (addr AND mask) equals its base, where the mask is NOT(span), span is the configured size minus one with every bit below its highest set bit also set (size rounded up to a power of two), and the base is stored with its span bits cleared.
- R2: On an ok completion sel_o is one-hot at the matched region index (bit i = region i) and offset_o equals addr AND span of that region.
- R3: The memory-controller region (index MC_IDX, default 0) is tested first and wins whenever it matches, even when a valid region overlaps it and even while its own valid bit is clear.
- R4: Any other region matches only while its valid bit is set; clearing it through the configuration port makes its addresses unmapped.
- R5: Among matching ordinary regions, the region of the most recent successful decode is chosen if it still matches; otherwise the lowest index wins. Every decode that matches refreshes this last-hit record.
- R6: An aligned access that matches no region completes with err_o = 1 (bus), ok_o = 0, sel_o = 0 and err_addr_o equal to the access address.
- R7: size_i encodes 0 = byte, 1 = halfword, 2 or 3 = word. A word access with addr[1:0] nonzero or a halfword with addr[0] set completes with err_o = 2 (alignment) before any decode, even at an unmapped address. Byte accesses never raise it.
- R8: With delay d >= 0 for the access direction (write delay when we_i = 1, read delay otherwise), ready_o rises d+1 clock edges after the edge that accepts the request. Errors complete after one edge.
- R9: A negative delay (two's complement, DLYW bits) for the access direction makes that access complete with err_o = 1 and sel_o = 0.
- R10: ready_o is a one-cycle pulse; when it is high exactly one of ok_o and a nonzero err_o holds. Out of reset ready_o, ok_o, err_o and sel_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write one region's configuration |
| cfg_idx_i | input | $clog2(NREG) | Region being written |
| cfg_base_i | input | AW | Region base (low bits cleared by the rounded size) |
| cfg_size_i | input | AW | Region size in bytes, rounded up to a power of two |
| cfg_rd_dly_i | input | DLYW | Signed read wait states, negative = reads unsupported |
| cfg_wr_dly_i | input | DLYW | Signed write wait states, negative = writes unsupported |
| cfg_valid_i | input | 1 | Region enable (ignored for the memory-controller region) |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access width code |
| addr_i | input | AW | Physical address |
| ready_o | output | 1 | Completion pulse |
| ok_o | output | 1 | Completion without error |
| err_o | output | 2 | 0 none, 1 bus, 2 alignment |
| sel_o | output | NREG | One-hot target select, held through wait and completion |
| offset_o | output | AW | Address offset within the selected region |
| err_addr_o | output | AW | Address of the last access that ended in error |

## Verification
A corrupted region register shows up on the first access into that region as a wrong sel_o, a wrong offset_o or a spurious bus error. A wrong stored delay shows as ready_o rising early or late on that same access. A stale last-hit record is only visible at an address covered by two ordinary regions. There it selects the wrong region on the first such access after the record should have changed, so the bench alternates between exclusive and shared addresses. A wrong priority for the memory-controller region only shows at an address it shares with a valid region, so the bench builds that overlap on purpose.

// File: rtl/region_decoder_pkg.sv
package region_decoder_pkg;
  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_BUS   = 2'd1,
    ERR_ALIGN = 2'd2
  } dec_err_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRSV = 2'd3
  } acc_size_e;
endpackage

// File: rtl/rd_region_table.sv
module rd_region_table #(
  parameter int NREG   = 4,
  parameter int AW     = 32,
  parameter int DLYW   = 5,
  parameter int MC_IDX = 0,
  localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [IW-1:0]              cfg_idx_i,
  input  logic [AW-1:0]              cfg_base_i,
  input  logic [AW-1:0]              cfg_size_i,
  input  logic [DLYW-1:0]            cfg_rd_dly_i,
  input  logic [DLYW-1:0]            cfg_wr_dly_i,
  input  logic                       cfg_valid_i,
  input  logic [AW-1:0]              addr_i,
  output logic [NREG-1:0]            hit_o,
  output logic [NREG-1:0][AW-1:0]    span_o,
  output logic [NREG-1:0][DLYW-1:0]  rd_dly_o,
  output logic [NREG-1:0][DLYW-1:0]  wr_dly_o
);
  logic [AW-1:0] span_n;

  // round size up to a power of two: smear (size-1) downward
  always_comb begin
    span_n = cfg_size_i - AW'(1);
    for (int i = AW - 2; i >= 0; i--) span_n[i] = span_n[i] | span_n[i+1];
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [AW-1:0]   base_q, span_q;
    logic [DLYW-1:0] rd_q, wr_q;
    logic            valid_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q  <= '0;
        span_q  <= '0;
        rd_q    <= '0;
        wr_q    <= '0;
        valid_q <= 1'b0;
      end else if (cfg_we_i && cfg_idx_i == IW'(r)) begin
        base_q  <= cfg_base_i & ~span_n;
        span_q  <= span_n;
        rd_q    <= cfg_rd_dly_i;
        wr_q    <= cfg_wr_dly_i;
        valid_q <= cfg_valid_i;
      end
    end

    if (r == MC_IDX) begin : g_mc
      assign hit_o[r] = ((addr_i & ~span_q) == base_q);
    end else begin : g_std
      assign hit_o[r] = valid_q && ((addr_i & ~span_q) == base_q);
    end

    assign span_o[r]   = span_q;
    assign rd_dly_o[r] = rd_q;
    assign wr_dly_o[r] = wr_q;
  end
endmodule

// File: rtl/rd_match_select.sv
module rd_match_select #(
  parameter int NREG   = 4,
  parameter int MC_IDX = 0,
  localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG-1:0] hit_i,
  input  logic            upd_i,
  output logic [IW-1:0]   idx_o,
  output logic            any_o
);
  logic [IW-1:0] last_q, scan;
  logic          last_vld_q;

  always_comb begin
    scan = '0;
    for (int i = NREG - 1; i >= 0; i--) if (hit_i[i]) scan = IW'(i);
  end

  always_comb begin
    if (hit_i[MC_IDX])                 idx_o = IW'(MC_IDX);
    else if (last_vld_q && hit_i[last_q]) idx_o = last_q;
    else                               idx_o = scan;
  end

  assign any_o = |hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q     <= '0;
      last_vld_q <= 1'b0;
    end else if (upd_i && any_o) begin
      last_q     <= idx_o;
      last_vld_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rd_wait_ctrl.sv
module rd_wait_ctrl
  import region_decoder_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 32,
  parameter int CW   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  dec_err_e        dec_err_i,
  input  logic [NREG-1:0] dec_sel_i,
  input  logic [AW-1:0]   dec_off_i,
  input  logic [AW-1:0]   dec_addr_i,
  input  logic [CW-1:0]   dec_dly_i,
  output logic            accept_o,
  output logic            idle_o,
  output logic            ready_o,
  output logic            ok_o,
  output logic [1:0]      err_o,
  output logic [NREG-1:0] sel_o,
  output logic [AW-1:0]   offset_o,
  output logic [AW-1:0]   err_addr_o
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RESP} st_e;

  st_e             st_q;
  logic [CW-1:0]   cnt_q;
  dec_err_e        err_q;
  logic [NREG-1:0] sel_q;
  logic [AW-1:0]   off_q, eaddr_q;

  assign idle_o   = (st_q == S_IDLE);
  assign accept_o = idle_o && req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      err_q   <= ERR_NONE;
      sel_q   <= '0;
      off_q   <= '0;
      eaddr_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_i) begin
          if (dec_err_i != ERR_NONE) begin
            err_q   <= dec_err_i;
            sel_q   <= '0;
            off_q   <= '0;
            eaddr_q <= dec_addr_i;
            st_q    <= S_RESP;
          end else begin
            err_q <= ERR_NONE;
            sel_q <= dec_sel_i;
            off_q <= dec_off_i;
            cnt_q <= dec_dly_i - CW'(1);
            st_q  <= (dec_dly_i == '0) ? S_RESP : S_WAIT;
          end
        end
        S_WAIT: begin
          if (cnt_q == '0) st_q <= S_RESP;
          else             cnt_q <= cnt_q - CW'(1);
        end
        S_RESP: begin
          st_q  <= S_IDLE;
          sel_q <= '0;
          err_q <= ERR_NONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ready_o    = (st_q == S_RESP);
  assign ok_o       = ready_o && (err_q == ERR_NONE);
  assign err_o      = ready_o ? err_q : ERR_NONE;
  assign sel_o      = sel_q;
  assign offset_o   = off_q;
  assign err_addr_o = eaddr_q;
endmodule

// File: rtl/region_decoder.sv
module region_decoder
  import region_decoder_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int AW     = 32,
  parameter int DLYW   = 5,
  parameter int MC_IDX = 0,
  localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int CW    = DLYW - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IW-1:0]    cfg_idx_i,
  input  logic [AW-1:0]    cfg_base_i,
  input  logic [AW-1:0]    cfg_size_i,
  input  logic [DLYW-1:0]  cfg_rd_dly_i,
  input  logic [DLYW-1:0]  cfg_wr_dly_i,
  input  logic             cfg_valid_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       size_i,
  input  logic [AW-1:0]    addr_i,
  output logic             ready_o,
  output logic             ok_o,
  output logic [1:0]       err_o,
  output logic [NREG-1:0]  sel_o,
  output logic [AW-1:0]    offset_o,
  output logic [AW-1:0]    err_addr_o
);
  logic [NREG-1:0]           hit;
  logic [NREG-1:0][AW-1:0]   span;
  logic [NREG-1:0][DLYW-1:0] rd_dly, wr_dly;
  logic [IW-1:0]             idx;
  logic                      any, misal, accept, idle;
  logic [DLYW-1:0]           dsel;
  dec_err_e                  dec_err;

  rd_region_table #(.NREG(NREG), .AW(AW), .DLYW(DLYW), .MC_IDX(MC_IDX)) u_table (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_base_i, .cfg_size_i,
    .cfg_rd_dly_i, .cfg_wr_dly_i, .cfg_valid_i, .addr_i,
    .hit_o(hit), .span_o(span), .rd_dly_o(rd_dly), .wr_dly_o(wr_dly)
  );

  // alignment is judged before decode; misaligned accesses leave the last-hit record alone
  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = addr_i[0];
      default: misal = |addr_i[1:0];
    endcase
  end

  rd_match_select #(.NREG(NREG), .MC_IDX(MC_IDX)) u_sel (
    .clk_i, .rst_ni, .hit_i(hit), .upd_i(accept && !misal), .idx_o(idx), .any_o(any)
  );

  assign dsel = we_i ? wr_dly[idx] : rd_dly[idx];

  always_comb begin
    if (misal)               dec_err = ERR_ALIGN;
    else if (!any)           dec_err = ERR_BUS;
    else if (dsel[DLYW-1])   dec_err = ERR_BUS;
    else                     dec_err = ERR_NONE;
  end

  rd_wait_ctrl #(.NREG(NREG), .AW(AW), .CW(CW)) u_wait (
    .clk_i, .rst_ni, .req_i,
    .dec_err_i(dec_err),
    .dec_sel_i(NREG'(1) << idx),
    .dec_off_i(addr_i & span[idx]),
    .dec_addr_i(addr_i),
    .dec_dly_i(dsel[CW-1:0]),
    .accept_o(accept), .idle_o(idle),
    .ready_o, .ok_o, .err_o, .sel_o, .offset_o, .err_addr_o
  );
endmodule

// File: rtl/region_decoder_chk.sv
module region_decoder_chk #(
  parameter int NREG = 4,
  parameter int AW   = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [1:0]      size_i,
  input logic [AW-1:0]   addr_i,
  input logic            idle_i,
  input logic            ready_o,
  input logic            ok_o,
  input logic [1:0]      err_o,
  input logic [NREG-1:0] sel_o
);
  a_r10_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  a_r10_ok_xor_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ok_o ^ (err_o != 2'd0)));

  a_r10_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> (!ready_o && sel_o == '0));

  a_r6_err_no_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && err_o != 2'd0) |-> sel_o == '0);

  a_r2_ok_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && ok_o) |-> $countones(sel_o) == 1);

  a_r2_sel_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  a_r7_word_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && req_i && size_i[1] && addr_i[1:0] != 2'd0) |=> (ready_o && err_o == 2'd2));

  a_r7_byte_never_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && req_i && size_i == 2'd0) |=> err_o != 2'd2);
endmodule

bind region_decoder region_decoder_chk #(.NREG(NREG), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .size_i(size_i), .addr_i(addr_i),
  .idle_i(idle), .ready_o(ready_o), .ok_o(ok_o), .err_o(err_o), .sel_o(sel_o)
);

// File: tb/region_decoder_tb_top.sv
`timescale 1ns/1ps
module region_decoder_tb_top;
  localparam int NREG = 4, AW = 32, DLYW = 5, IW = 2;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            cfg_we = 0, cfg_valid = 0;
  logic [IW-1:0]   cfg_idx = '0;
  logic [AW-1:0]   cfg_base = '0, cfg_size = '0;
  logic [DLYW-1:0] cfg_rd = '0, cfg_wr = '0;
  logic            req = 0, we = 0;
  logic [1:0]      size = 2'd2;
  logic [AW-1:0]   addr = '0;
  logic            ready, ok;
  logic [1:0]      err;
  logic [NREG-1:0] sel;
  logic [AW-1:0]   offset, err_addr;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  region_decoder #(.NREG(NREG), .AW(AW), .DLYW(DLYW), .MC_IDX(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_base_i(cfg_base), .cfg_size_i(cfg_size), .cfg_rd_dly_i(cfg_rd),
    .cfg_wr_dly_i(cfg_wr), .cfg_valid_i(cfg_valid), .req_i(req), .we_i(we),
    .size_i(size), .addr_i(addr), .ready_o(ready), .ok_o(ok), .err_o(err),
    .sel_o(sel), .offset_o(offset), .err_addr_o(err_addr)
  );

  // last completion as seen at the ports
  int          r_lat;
  logic        r_ok;
  logic [1:0]  r_err;
  logic [3:0]  r_sel;
  logic [31:0] r_off, r_eaddr;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input logic [31:0] base, input logic [31:0] sz,
                     input int rd, input int wr, input bit vld);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_base = base; cfg_size = sz;
    cfg_rd = DLYW'(rd); cfg_wr = DLYW'(wr); cfg_valid = vld;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input bit w, input logic [1:0] sz, input logic [31:0] a);
    @(negedge clk);
    req = 1; we = w; size = sz; addr = a;
    r_lat = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      r_lat++;
      if (ready) break;
    end
    r_ok = ok; r_err = err; r_sel = sel; r_off = offset; r_eaddr = err_addr;
    req = 0;
  endtask

  task automatic expect_ok(input string rq, input int lat, input logic [3:0] s, input logic [31:0] off);
    chk({rq, " ok"}, 32'(r_ok), 32'd1);
    chk({rq, " err"}, 32'(r_err), 32'd0);
    chk({rq, " sel"}, 32'(r_sel), 32'(s));
    chk({rq, " offset"}, r_off, off);
    chk({rq, " latency"}, 32'(r_lat), 32'(lat));
  endtask

  task automatic expect_err(input string rq, input logic [1:0] code, input logic [31:0] a);
    chk({rq, " ok"}, 32'(r_ok), 32'd0);
    chk({rq, " err"}, 32'(r_err), 32'(code));
    chk({rq, " sel"}, 32'(r_sel), 32'd0);
    chk({rq, " latency"}, 32'(r_lat), 32'd1);
    if (code == 2'd1) chk({rq, " err_addr"}, r_eaddr, a);
  endtask

  task automatic t_reset;
    chk("R10 reset ready", 32'(ready), 0);
    chk("R10 reset ok", 32'(ok), 0);
    chk("R10 reset err", 32'(err), 0);
    chk("R10 reset sel", 32'(sel), 0);
  endtask

  task automatic setup_regions;
    cfg(0, 32'h0000_0000, 32'h1000, 2, 3, 0);   // memory-controller region, valid clear
    cfg(1, 32'h0000_2010, 32'h0300, 1, 0, 1);   // size rounds to 0x400, base to 0x2000
    cfg(2, 32'h0000_4000, 32'h0800, 0, 4, 1);
    cfg(3, 32'h0000_4000, 32'h1000, -1, 1, 1);  // reads unsupported
  endtask

  task automatic t_rounding;
    access(0, 2'd2, 32'h2388);
    expect_ok("R1 R2 rounded size", 2, 4'b0010, 32'h388);
    access(1, 2'd0, 32'h23FF);
    expect_ok("R1 top byte", 1, 4'b0010, 32'h3FF);
  endtask

  task automatic t_wait;
    access(0, 2'd2, 32'h0100);
    expect_ok("R8 mc read d2", 3, 4'b0001, 32'h100);
    access(1, 2'd2, 32'h0104);
    expect_ok("R8 mc write d3", 4, 4'b0001, 32'h104);
    access(1, 2'd2, 32'h2004);
    expect_ok("R8 write d0", 1, 4'b0010, 32'h4);
    access(0, 2'd2, 32'h4004);
    expect_ok("R8 R5 read d0 lowest index", 1, 4'b0100, 32'h4);
  endtask

  task automatic t_cache;
    access(1, 2'd2, 32'h4900);
    expect_ok("R5 exclusive region 3", 2, 4'b1000, 32'h900);
    access(1, 2'd2, 32'h4100);
    expect_ok("R5 shared addr keeps last hit", 2, 4'b1000, 32'h100);
    access(0, 2'd0, 32'h2001);
    expect_ok("R5 move to region 1", 2, 4'b0010, 32'h1);
    access(1, 2'd2, 32'h4100);
    expect_ok("R5 shared addr falls to lowest", 5, 4'b0100, 32'h100);
    access(1, 2'd2, 32'h4200);
    expect_ok("R5 refreshed to region 2", 5, 4'b0100, 32'h200);
  endtask

  task automatic t_mc_priority;
    cfg(1, 32'h0000_0800, 32'h0400, 1, 0, 1);
    access(0, 2'd2, 32'h0900);
    expect_ok("R3 mc wins overlap", 3, 4'b0001, 32'h900);
    access(0, 2'd2, 32'h0904);
    expect_ok("R3 mc wins after mc hit", 3, 4'b0001, 32'h904);
    cfg(1, 32'h0000_2010, 32'h0300, 1, 0, 1);
  endtask

  task automatic t_valid_gate;
    cfg(1, 32'h0000_2010, 32'h0300, 1, 0, 0);
    access(0, 2'd2, 32'h2000);
    expect_err("R4 disabled region", 2'd1, 32'h2000);
    cfg(1, 32'h0000_2010, 32'h0300, 1, 0, 1);
    access(0, 2'd2, 32'h2000);
    expect_ok("R4 re-enabled region", 2, 4'b0010, 32'h0);
  endtask

  task automatic t_unmapped;
    access(0, 2'd2, 32'h8000_0000);
    expect_err("R6 unmapped read", 2'd1, 32'h8000_0000);
    access(1, 2'd1, 32'h0001_2342);
    expect_err("R6 unmapped write", 2'd1, 32'h0001_2342);
  endtask

  task automatic t_align;
    access(0, 2'd2, 32'h2002);
    expect_err("R7 word low bits", 2'd2, 32'h0);
    access(0, 2'd3, 32'h2001);
    expect_err("R7 reserved code as word", 2'd2, 32'h0);
    access(0, 2'd1, 32'h2001);
    expect_err("R7 half bit0", 2'd2, 32'h0);
    access(0, 2'd1, 32'h2002);
    expect_ok("R7 half aligned", 2, 4'b0010, 32'h2);
    access(0, 2'd0, 32'h2003);
    expect_ok("R7 byte odd", 2, 4'b0010, 32'h3);
    access(0, 2'd2, 32'h8000_0001);
    expect_err("R7 align before decode", 2'd2, 32'h0);
  endtask

  task automatic t_neg_delay;
    access(0, 2'd2, 32'h4900);
    expect_err("R9 read unsupported", 2'd1, 32'h4900);
    access(1, 2'd2, 32'h4900);
    expect_ok("R9 write still supported", 2, 4'b1000, 32'h900);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    setup_regions;
    t_rounding;
    t_wait;
    t_cache;
    t_mc_priority;
    t_valid_gate;
    t_unmapped;
    t_align;
    t_neg_delay;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule